// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between a serial slave front end and a modelled delta-sigma converter core. It owns the converter's 8-bit configuration register, decides when a conversion starts and ends, and holds the latest converted value. Conversions run back to back in continuous mode or one at a time in one-shot mode. Each conversion lasts a number of system clock cycles set by the selected data rate. After reset, conversions wait for a start-up delay before they begin.

The converted value comes from a signed sample input wider than the result. It is sampled on the cycle a conversion ends, clamped to the resolution that goes with the selected rate, and kept sign-extended to 18 bits. A ready flag tells the master whether the held result is fresh. In this flag, 0 means new data. The flag is cleared when a conversion ends and set again in one of two ways, depending on the mode: in continuous mode by a read-complete strobe, and in one-shot mode by a new start command. Two broadcast commands are accepted, one that resets the block and one that starts a conversion.

The result is a held register, not a stream. No valid/ready handshake is used and there is no back-pressure. A newer conversion simply overwrites an unread value, and `rd_done` serves as the consumer's acknowledgement.

Top module: `adc_conv_seq`

## Requirements
- R1: During and right after reset, `cfg_rdata` reads 8'h90, `rdy` is 1, `result` is 0 and `standby` is 0.
- R2: The configuration byte is laid out as bit 7 ready/start, bits 6:5 spare channel bits (stored and read back), bit 4 mode (1 = continuous, 0 = one-shot), bits 3:2 rate, and bits 1:0 gain (stored only). On a write, bits 6:0 become visible on `cfg_rdata` on the next cycle.
- R3: The first conversion after reset starts STARTUP_CYC cycles after reset is released. No result appears, and `rdy` stays 1, before that.
- R4: A conversion ends exactly PER cycles after it starts. Rate code 00 uses PER_12, 01 uses PER_14, 10 uses PER_16 and 11 uses PER_18.
- R5: In continuous mode, every finished conversion overwrites `result`, clears `rdy` to 0, and starts the next conversion in the same cycle. `result` changes at no other time except reset.
- R6: In continuous mode, a `rd_done` pulse sets `rdy` to 1. If a conversion finishes in the same cycle, `rdy` ends at 0.
- R7: In one-shot mode, a finished conversion updates `result`, clears `rdy` and enters standby. A `rd_done` pulse does not change `rdy` in this mode.
- R8: A write with bit 4 = 0 and bit 7 = 1 starts one conversion and `rdy` reads 1 while it runs. A write with bits 7 and 4 both 0 starts nothing and leaves `result`, `rdy` and `standby` unchanged.
- R9: A write with bit 4 = 1 restarts conversion at once, whatever bit 7 holds. The conversion in flight is discarded and `rdy` reads 1.
- R10: The result is clamped to the range -2^(N-1) .. 2^(N-1)-1, where N = 12, 14, 16 or 18 for rate codes 00..11, and is sign-extended to 18 bits. It never wraps.
- R11: `gc_reset` aborts any conversion, restores 8'h90, sets `rdy` to 1 and `result` to 0, and reruns the start-up delay.
- R12: `gc_convert` forces one-shot mode, keeps the channel, rate and gain bits, and runs one conversion.
- R13: `standby` is high only in one-shot mode, when no conversion is running and the start-up delay has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte written with `cfg_wr` |
| rd_done | input | 1 | Master finished reading the result |
| gc_reset | input | 1 | Broadcast reset command strobe |
| gc_convert | input | 1 | Broadcast conversion command strobe |
| smp_data | input | SAMPLE_W | Signed sample from the modelled core |
| result | output | 18 | Latched, clamped, sign-extended result |
| rdy | output | 1 | Ready flag, 0 = unread new result |
| standby | output | 1 | One-shot idle indicator |
| cfg_rdata | output | 8 | Configuration readback with ready flag in bit 7 |

## Verification
The bench builds the block with a 24-bit sample, a start-up delay of 20 cycles and conversion periods of 6, 8, 10 and 12 cycles. These short values let a single run reach the first conversion after reset, and later a second start-up delay after a broadcast reset. They also allow one-shot conversions at all four rates, each timed to the exact edge. Samples well beyond each resolution's limits, on both the positive and negative side, exercise the clamp at every width. In continuous mode, a read strobe is placed on the very edge a conversion completes, to show which of the two wins.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int RES_W = 18;

  typedef enum logic [1:0] {
    RATE_12 = 2'b00,
    RATE_14 = 2'b01,
    RATE_16 = 2'b10,
    RATE_18 = 2'b11
  } rate_e;

  typedef struct packed {
    logic       rdy;
    logic [1:0] chan;
    logic       cont;
    rate_e      rate;
    logic [1:0] gain;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = cfg_t'(8'h90);

  typedef enum logic [1:0] {
    PH_WARM,
    PH_CONV,
    PH_IDLE
  } phase_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  input  logic       gc_reset,
  input  logic       gc_convert,
  output logic [1:0] chan,
  output logic       cont,
  output rate_e      rate,
  output logic [1:0] gain,
  output logic       start_req
);

  cfg_t wr_cfg;
  assign wr_cfg = cfg_t'(cfg_wdata);

  // Restart request: broadcast convert, or a write that selects continuous
  // mode or asks for a one-shot start.
  assign start_req = !gc_reset &&
                     (gc_convert || (cfg_wr && (wr_cfg.cont || wr_cfg.rdy)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan <= CFG_DEFAULT.chan;
      cont <= CFG_DEFAULT.cont;
      rate <= CFG_DEFAULT.rate;
      gain <= CFG_DEFAULT.gain;
    end else if (gc_reset) begin
      chan <= CFG_DEFAULT.chan;
      cont <= CFG_DEFAULT.cont;
      rate <= CFG_DEFAULT.rate;
      gain <= CFG_DEFAULT.gain;
    end else if (gc_convert) begin
      cont <= 1'b0;
    end else if (cfg_wr) begin
      chan <= wr_cfg.chan;
      cont <= wr_cfg.cont;
      rate <= wr_cfg.rate;
      gain <= wr_cfg.gain;
    end
  end

endmodule

// File: rtl/adc_rdy_flag.sv
module adc_rdy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic gc_reset,
  input  logic start_req,
  input  logic conv_done,
  input  logic rd_done,
  input  logic cont,
  output logic rdy
);

  // Ready flag is active low: 0 means an unread fresh result.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b1;
    end else if (gc_reset || start_req) begin
      rdy <= 1'b1;
    end else if (conv_done) begin
      rdy <= 1'b0;
    end else if (rd_done && cont) begin
      rdy <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int STARTUP_CYC = 300,
  parameter int PER_12      = 4167,
  parameter int PER_14      = 16667,
  parameter int PER_16      = 66667,
  parameter int PER_18      = 266667
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  gc_reset,
  input  logic  start_req,
  input  logic  cont,
  input  rate_e rate,
  output logic  conv_done,
  output logic  in_warm,
  output logic  in_idle
);

  localparam int MAX_CNT = max_int(max_int(max_int(PER_12, PER_14),
                                           max_int(PER_16, PER_18)),
                                   STARTUP_CYC);
  localparam int CNT_W = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(STARTUP_CYC - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] conv_last;
  logic             pend;

  // Period follows the live rate field; a rate change that starts nothing
  // only happens through a one-shot write without the start bit.
  always_comb begin
    unique case (rate)
      RATE_12: conv_last = CNT_W'(PER_12 - 1);
      RATE_14: conv_last = CNT_W'(PER_14 - 1);
      RATE_16: conv_last = CNT_W'(PER_16 - 1);
      default: conv_last = CNT_W'(PER_18 - 1);
    endcase
  end

  assign conv_done = (phase == PH_CONV) && (cnt >= conv_last) &&
                     !start_req && !gc_reset;
  assign in_warm   = (phase == PH_WARM);
  assign in_idle   = (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_WARM;
      cnt   <= '0;
      pend  <= 1'b0;
    end else if (gc_reset) begin
      phase <= PH_WARM;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      unique case (phase)
        PH_WARM: begin
          if (cnt == WARM_LAST) begin
            cnt   <= '0;
            pend  <= 1'b0;
            phase <= (cont || pend || start_req) ? PH_CONV : PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            if (start_req) pend <= 1'b1;
          end
        end
        PH_CONV: begin
          if (start_req) begin
            cnt <= '0;
          end else if (cnt >= conv_last) begin
            cnt   <= '0;
            phase <= cont ? PH_CONV : PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (start_req) begin
            cnt   <= '0;
            phase <= PH_CONV;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_sat.sv
module adc_sat
  import adc_seq_pkg::*;
#(
  parameter int IN_W = 24
) (
  input  logic signed [IN_W-1:0]  din,
  input  rate_e                   rate,
  output logic signed [RES_W-1:0] dout
);

  localparam int NUM_RATES = 4;

  logic signed [RES_W-1:0] cand [NUM_RATES];

  // One clamp per resolution, then pick by rate.
  for (genvar k = 0; k < NUM_RATES; k++) begin : g_clamp
    localparam int NB = 12 + 2 * k;
    localparam logic signed [IN_W-1:0] HI = IN_W'((64'sd1 <<< (NB - 1)) - 64'sd1);
    localparam logic signed [IN_W-1:0] LO = ~HI;
    assign cand[k] = (din > HI) ? RES_W'(HI) :
                     (din < LO) ? RES_W'(LO) :
                                  din[RES_W-1:0];
  end

  assign dout = cand[rate];

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int STARTUP_CYC = 300,
  parameter int PER_12      = 4167,
  parameter int PER_14      = 16667,
  parameter int PER_16      = 66667,
  parameter int PER_18      = 266667
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [7:0]                 cfg_wdata,
  input  logic                       rd_done,
  input  logic                       gc_reset,
  input  logic                       gc_convert,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  output logic signed [RES_W-1:0]    result,
  output logic                       rdy,
  output logic                       standby,
  output logic [7:0]                 cfg_rdata
);

  logic [1:0]              chan;
  logic                    cont;
  rate_e                   rate;
  logic [1:0]              gain;
  logic                    start_req;
  logic                    conv_done;
  logic                    in_warm;
  logic                    in_idle;
  logic signed [RES_W-1:0] sat_val;
  cfg_t                    rd_cfg;

  adc_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .gc_reset   (gc_reset),
    .gc_convert (gc_convert),
    .chan       (chan),
    .cont       (cont),
    .rate       (rate),
    .gain       (gain),
    .start_req  (start_req)
  );

  adc_conv_timer #(
    .STARTUP_CYC (STARTUP_CYC),
    .PER_12      (PER_12),
    .PER_14      (PER_14),
    .PER_16      (PER_16),
    .PER_18      (PER_18)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .gc_reset  (gc_reset),
    .start_req (start_req),
    .cont      (cont),
    .rate      (rate),
    .conv_done (conv_done),
    .in_warm   (in_warm),
    .in_idle   (in_idle)
  );

  adc_rdy_flag u_rdy (
    .clk       (clk),
    .rst_n     (rst_n),
    .gc_reset  (gc_reset),
    .start_req (start_req),
    .conv_done (conv_done),
    .rd_done   (rd_done),
    .cont      (cont),
    .rdy       (rdy)
  );

  adc_sat #(.IN_W(SAMPLE_W)) u_sat (
    .din  (smp_data),
    .rate (rate),
    .dout (sat_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else if (gc_reset) begin
      result <= '0;
    end else if (conv_done) begin
      result <= sat_val;
    end
  end

  assign standby = in_idle;

  always_comb begin
    rd_cfg.rdy  = rdy;
    rd_cfg.chan = chan;
    rd_cfg.cont = cont;
    rd_cfg.rate = rate;
    rd_cfg.gain = gain;
  end
  assign cfg_rdata = rd_cfg;

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [7:0]  cfg_wdata,
  input logic        rd_done,
  input logic        gc_reset,
  input logic        gc_convert,
  input logic [17:0] result,
  input logic        rdy,
  input logic        standby,
  input logic [7:0]  cfg_rdata,
  input logic        conv_done,
  input logic        in_warm
);

  p_done_clears_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !rdy);

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !gc_reset) |=> $stable(result));

  p_cont_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && cfg_rdata[4] && !conv_done && !gc_reset) |=> rdy);

  p_oneshot_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !cfg_rdata[4] && !conv_done && !cfg_wr && !gc_reset && !gc_convert)
      |=> $stable(rdy));

  p_cont_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[4] && !gc_reset && !gc_convert) |=> (rdy && !standby));

  p_gc_default_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (cfg_rdata == 8'h90 && result == 18'd0 && !standby));

  p_warm_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_warm |-> rdy);

  p_standby_oneshot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !cfg_rdata[4]);

endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .rd_done    (rd_done),
  .gc_reset   (gc_reset),
  .gc_convert (gc_convert),
  .result     (result),
  .rdy        (rdy),
  .standby    (standby),
  .cfg_rdata  (cfg_rdata),
  .conv_done  (conv_done),
  .in_warm    (in_warm)
);

// File: tb/test_adc_conv_seq.sv
`timescale 1ns/1ps
module test_adc_conv_seq;

  localparam int SW  = 24;
  localparam int ST  = 20;
  localparam int P12 = 6;
  localparam int P14 = 8;
  localparam int P16 = 10;
  localparam int P18 = 12;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 cfg_wr = 1'b0;
  logic [7:0]           cfg_wdata = 8'h00;
  logic                 rd_done = 1'b0;
  logic                 gc_reset = 1'b0;
  logic                 gc_convert = 1'b0;
  logic signed [SW-1:0] smp_data = '0;
  logic signed [17:0]   result;
  logic                 rdy;
  logic                 standby;
  logic [7:0]           cfg_rdata;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  adc_conv_seq #(
    .SAMPLE_W(SW), .STARTUP_CYC(ST),
    .PER_12(P12), .PER_14(P14), .PER_16(P16), .PER_18(P18)
  ) i_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rd_done(rd_done), .gc_reset(gc_reset), .gc_convert(gc_convert),
    .smp_data(smp_data), .result(result), .rdy(rdy), .standby(standby),
    .cfg_rdata(cfg_rdata)
  );

  function automatic int per_of(input int r);
    case (r)
      0: return P12;
      1: return P14;
      2: return P16;
      default: return P18;
    endcase
  endfunction

  function automatic int sat_exp(input int v, input int r);
    int nb = 12 + 2 * r;
    int hi = (1 << (nb - 1)) - 1;
    int lo = -(1 << (nb - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    cfg_wdata = d;
    cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_standby(output int n);
    n = 0;
    while (!standby && n < 1000) begin
      tick(1);
      n++;
    end
  endtask

  task automatic wait_rdy_low(output int n);
    n = 0;
    while (rdy && n < 1000) begin
      tick(1);
      n++;
    end
  endtask

  // Driver: one-shot start, expected value goes to the scoreboard queue.
  task automatic oneshot(input int r, input int g, input int v);
    int n;
    logic [7:0] d;
    d = {1'b1, 2'b00, 1'b0, 2'(r), 2'(g)};
    smp_data = SW'(v);
    exp_q.push_back(sat_exp(v, r));
    pulse_wr(d);
    chk("R8 rdy high while one-shot runs", rdy, 1);
    chk("R2 readback after one-shot write", cfg_rdata, {1'b1, d[6:0]});
    wait_standby(n);
    chk("R4 one-shot period", n, per_of(r));
    chk("R7 rdy cleared after one-shot", rdy, 0);
  endtask

  // Monitor: compare the held result whenever a one-shot conversion ends.
  initial begin
    int e;
    forever begin
      @(posedge standby);
      #1;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R7: standby rose with no expected result, actual %0d expected none",
                 result);
      end else begin
        e = exp_q.pop_front();
        chk("R10 scoreboard result", result, e);
      end
    end
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R1 reset state
    tick(3);
    chk("R1 reset cfg", cfg_rdata, 8'h90);
    chk("R1 reset rdy", rdy, 1);
    chk("R1 reset result", result, 0);
    chk("R1 reset standby", standby, 0);
    smp_data = SW'(1000);
    rst_n = 1'b1;

    // R3 start-up delay then first continuous conversion
    tick(ST + P12 - 1);
    chk("R3 no result before start-up delay", rdy, 1);
    tick(1);
    chk("R3 first conversion rdy", rdy, 0);
    chk("R5 first result", result, 1000);

    // R5 back-to-back, unread overwrite, R10 positive clamp 12 bit
    smp_data = SW'(5000);
    tick(P12);
    chk("R5 rdy stays 0 unread", rdy, 0);
    chk("R10 clamp +12", result, 2047);
    chk("R13 standby low in continuous", standby, 0);

    // R6 read sets rdy
    rd_done = 1'b1;
    tick(1);
    rd_done = 1'b0;
    chk("R6 read sets rdy", rdy, 1);
    smp_data = SW'(-3000);
    tick(P12 - 1);
    chk("R5 next conversion clears rdy", rdy, 0);
    chk("R10 clamp -12", result, -2048);

    // R9 continuous write restarts mid conversion; R2 field layout
    smp_data = SW'(9000);
    tick(2);
    pulse_wr(8'h76);
    chk("R2 readback 0x76", cfg_rdata, 8'hF6);
    chk("R9 rdy set by continuous write", rdy, 1);
    wait_rdy_low(n);
    chk("R9 restart period 14-bit", n, P14);
    chk("R10 clamp +14", result, 8191);

    // One-shot series through the scoreboard
    oneshot(2, 1, -40000);
    rd_done = 1'b1;
    tick(1);
    rd_done = 1'b0;
    chk("R7 read ignored in one-shot", rdy, 0);
    chk("R7 standby kept after read", standby, 1);
    pulse_wr(8'h0C);
    tick(P18 + 2);
    chk("R8 no start without bit7", standby, 1);
    chk("R8 rdy unchanged", rdy, 0);
    chk("R8 result unchanged", result, -32768);
    chk("R2 readback 0x0C", cfg_rdata, 8'h0C);

    oneshot(0, 0, 100);
    oneshot(0, 1, -2048);
    oneshot(0, 2, 2048);
    oneshot(1, 3, -9000);
    oneshot(1, 0, 8191);
    oneshot(2, 1, 32767);
    oneshot(2, 2, 70000);
    oneshot(3, 3, -131072);
    oneshot(3, 0, -500000);
    oneshot(3, 1, 131071);
    oneshot(3, 2, 12345);

    // R12 broadcast conversion from continuous mode
    pulse_wr(8'h7F);
    smp_data = SW'(-200000);
    exp_q.push_back(sat_exp(-200000, 3));
    gc_convert = 1'b1;
    tick(1);
    gc_convert = 1'b0;
    chk("R12 forces one-shot, keeps fields", cfg_rdata, 8'hEF);
    wait_standby(n);
    chk("R12 conversion period", n, P18);
    chk("R13 standby after one-shot", standby, 1);

    // R11 broadcast reset mid conversion
    pulse_wr(8'h14);
    tick(3);
    gc_reset = 1'b1;
    tick(1);
    gc_reset = 1'b0;
    chk("R11 cfg default", cfg_rdata, 8'h90);
    chk("R11 rdy", rdy, 1);
    chk("R11 result cleared", result, 0);
    chk("R11 standby", standby, 0);
    smp_data = SW'(77);
    tick(ST + P12 - 1);
    chk("R11 start-up delay rerun", rdy, 1);
    tick(1);
    chk("R11 first result after reset", result, 77);

    // R6 completion wins over a read in the same cycle
    tick(P12 - 1);
    rd_done = 1'b1;
    tick(1);
    rd_done = 1'b0;
    chk("R6 completion beats read", rdy, 0);

    tick(2);
    chk("R7 scoreboard drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule